// File: doc/BRIEF.md
# Power-State Sequencer with Qualified Wake-Up

This block decides which power state a contactless transceiver is in and when it may move to another one. After reset it sits in a power-up state with the fast clock off. It waits for a guard interval, measured in slow-clock ticks, and then for a low pulse on the active-low wake pin. Only a pulse held low for a minimum number of slow ticks counts. A qualified pulse starts the fast oscillator. The block moves to ready when the oscillator reports ready, or when a programmable setup count runs out, whichever comes first.

From the active states (ready, reader, card emulation) the host can select a protocol. It can also enter hibernate, sleep/field-detect or tag-detect, or request a reset. The reset request takes effect only once slave select has returned high. In the low-power states the block accepts no host commands. Hibernate leaves only on a qualified wake pulse. Sleep and tag-detect leave on whichever sources the host enabled in a wake mask when it issued the command.

The straps that select the serial interface are captured on the falling edge of the wake pin. This happens only in the power-up and hibernate states.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: During and right after reset, state is power-up (code 0), hf_clk_en is 0 and if_sel is 0.
- R2: After reset, wake-pin activity is ignored until POR_GUARD_TICKS slow ticks have elapsed. A pulse that ends before then leaves the state at power-up.
- R3: Power-up (0) and hibernate (1) are left only when wake_n stays low for at least MIN_LOW_TICKS slow ticks, and then go to oscillator wait (code 4). A shorter low pulse is ignored.
- R4: if_sel is loaded only on a falling edge of wake_n while in power-up or hibernate. It becomes 1 when strap0=1 and strap1=0, and 0 otherwise. A wake from sleep or tag-detect leaves it unchanged.
- R5: Oscillator wait (4) goes to ready (code 5) on the first cycle osc_ready is high, or after OSC_SETUP_CYC cycles, whichever is first.
- R6: Host command codes on cmd_op are 1 hibernate, 2 sleep, 3 tag-detect, 4 reader select, 5 card-emulation select and 6 reset. A command is accepted only in ready, reader (6) or card (7). Code 4 gives state 6, code 5 gives state 7, and any other code leaves the state unchanged.
- R7: In hibernate, sleep (2) and tag-detect (3) every host command is ignored. hf_clk_en is 0 in states 0 to 3 and 1 in states 4 to 7.
- R8: A reset command (6) is held pending while slave select is low and executes, giving state 0, once slave select is high. While a reset is pending, other commands are ignored.
- R9: cmd_arg is captured as the wake mask with command 2 or 3: bit0 timer strobe, bit1 wake pin low, bit2 slave select low, bit3 detector strobe. In sleep, an enabled source (detector = fld_evt) moves the state to 4. A disabled source has no effect.
- R10: In tag-detect, the same mask applies with the tag_evt strobe as the detector. A fld_evt strobe never wakes tag-detect, and a tag_evt strobe never wakes sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| wake_n | input | 1 | Asynchronous active-low wake pin |
| ss_n | input | 1 | Asynchronous active-low slave select |
| strap0 | input | 1 | Interface-select strap 0 |
| strap1 | input | 1 | Interface-select strap 1 |
| tmr_evt | input | 1 | Wake-timer expiry strobe |
| fld_evt | input | 1 | Field-detector event strobe |
| tag_evt | input | 1 | Tag-detector event strobe |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 4 | Host command code |
| cmd_arg | input | 4 | Wake mask for low-power commands |
| osc_ready | input | 1 | Fast oscillator settled |
| state | output | 3 | Current power state code |
| hf_clk_en | output | 1 | Fast-clock enable |
| if_sel | output | 1 | Serial interface selected flag |

## Verification
Two things can fall in the same cycle: a pending reset request becoming executable because slave select rises, and a fresh protocol-select command. The bench holds slave select low, issues the reset, and then raises slave select while a card-select command is held on the command port across the rise. It judges the outcome by the state settling at power-up rather than card emulation, and by the state staying there afterwards. A second coincidence is a low-power entry carrying a mask, followed by a detector strobe of the wrong kind. This is exercised by random mixing of state, mask and source, with the expected wake computed from the mask rules.

// File: rtl/pwr_wake_pkg.sv
// Package: state codes, command codes and wake-mask bit indices shared
// by the power-state sequencer and its bench-visible encodings.
package pwr_wake_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP   = 3'd0,
        ST_HIBER   = 3'd1,
        ST_SLEEP   = 3'd2,
        ST_TAGDET  = 3'd3,
        ST_OSCWAIT = 3'd4,
        ST_READY   = 3'd5,
        ST_READER  = 3'd6,
        ST_CARD    = 3'd7
    } pwr_state_e;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] OP_HIBER  = 4'd1;
    localparam logic [CMD_W-1:0] OP_SLEEP  = 4'd2;
    localparam logic [CMD_W-1:0] OP_TAGDET = 4'd3;
    localparam logic [CMD_W-1:0] OP_READER = 4'd4;
    localparam logic [CMD_W-1:0] OP_CARD   = 4'd5;
    localparam logic [CMD_W-1:0] OP_RESET  = 4'd6;

    localparam int WAKE_SRC_N = 4;
    localparam int WK_TIMER   = 0;
    localparam int WK_PIN     = 1;
    localparam int WK_SS      = 2;
    localparam int WK_DET     = 3;

    // True for the states in which the host may talk to the block.
    function automatic logic is_active(pwr_state_e s);
        return (s == ST_READY) || (s == ST_READER) || (s == ST_CARD);
    endfunction

endpackage

// File: rtl/pwr_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous pins.
// Assumes each bit is an independent level (no bus coherency needed).
// Reset value is a parameter so idle-high pins reset high.
module pwr_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift one synchronizer rank per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[i] <= RST_VAL;
                end else if (i == 0) begin
                    stage_q[i] <= d;
                end else begin
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_pulse_qual.sv
// Wake-pulse qualifier. Counts slow ticks from reset as a power-on guard,
// then, while armed, measures how long the synchronized pin stays low.
// Emits a falling-edge strobe (for strap capture) and a one-cycle
// qualification strobe once the low time reaches MIN_LOW_TICKS.
// Assumes pin_low is already synchronized to clk.
module pwr_pulse_qual #(
    parameter int MIN_LOW_TICKS   = 8,
    parameter int POR_GUARD_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    input  logic pin_low,
    input  logic arm,
    output logic fall_evt,
    output logic qual_evt
);

    localparam int GUARD_W = $clog2(POR_GUARD_TICKS + 1);
    localparam int LOW_W   = $clog2(MIN_LOW_TICKS + 1);
    localparam logic [GUARD_W-1:0] GUARD_END = GUARD_W'(POR_GUARD_TICKS);
    localparam logic [LOW_W-1:0]   LOW_LAST  = LOW_W'(MIN_LOW_TICKS - 1);

    logic [GUARD_W-1:0] guard_cnt;
    logic               guard_done;
    logic [LOW_W-1:0]   low_cnt;
    logic               fired_q;
    logic               qual_q;
    logic               pin_low_d;

    assign guard_done = (guard_cnt == GUARD_END);

    // Power-on guard: count slow ticks once after reset, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_cnt <= '0;
        end else if (slow_tick && !guard_done) begin
            guard_cnt <= guard_cnt + 1'b1;
        end
    end

    // Delayed pin level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_low_d <= 1'b0;
        end else begin
            pin_low_d <= pin_low;
        end
    end

    // Low-time counter: restarts whenever the pin is high or disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            fired_q <= 1'b0;
            qual_q  <= 1'b0;
        end else begin
            qual_q <= 1'b0;
            if (!arm || !pin_low || !guard_done) begin
                low_cnt <= '0;
                fired_q <= 1'b0;
            end else if (slow_tick && !fired_q) begin
                low_cnt <= low_cnt + 1'b1;
                if (low_cnt == LOW_LAST) begin
                    fired_q <= 1'b1;
                    qual_q  <= 1'b1;
                end
            end
        end
    end

    assign fall_evt = arm && guard_done && pin_low && !pin_low_d;
    assign qual_evt = qual_q;

    // The low-time counter never runs past its threshold.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= LOW_W'(MIN_LOW_TICKS));

    // A qualification strobe requires the pin to have been low.
    p_qual_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q |-> $past(pin_low));

    // No qualification before the power-on guard has completed.
    p_guard_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q |-> $past(guard_done));

endmodule

// File: rtl/pwr_wake_sel.sv
// Wake-source selector for the sleep and tag-detect states. Holds the
// host-supplied wake mask and combines it with the live event sources.
// The detector input is the field detector in sleep and the tag
// detector in tag-detect. Assumes strobes are synchronous to clk.
module pwr_wake_sel
    import pwr_wake_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mask_load,
    input  logic [WAKE_SRC_N-1:0] mask_in,
    input  logic                  in_sleep,
    input  logic                  in_tag,
    input  logic                  tmr_evt,
    input  logic                  pin_low,
    input  logic                  ss_low,
    input  logic                  fld_evt,
    input  logic                  tag_evt,
    output logic                  wake_hit
);

    logic [WAKE_SRC_N-1:0] mask_q;
    logic [WAKE_SRC_N-1:0] src_vec;

    // Capture the wake mask with each low-power entry command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_load) begin
            mask_q <= mask_in;
        end
    end

    // Gather the live sources into mask bit order.
    always_comb begin
        src_vec            = '0;
        src_vec[WK_TIMER]  = tmr_evt;
        src_vec[WK_PIN]    = pin_low;
        src_vec[WK_SS]     = ss_low;
        src_vec[WK_DET]    = in_sleep ? fld_evt : tag_evt;
    end

    assign wake_hit = (in_sleep || in_tag) && |(mask_q & src_vec);

endmodule

// File: rtl/pwr_wake_ctrl.sv
// Power-state sequencer top. Tracks power-up, hibernate, sleep,
// tag-detect, oscillator wait, ready, reader and card emulation.
// Wake from power-up/hibernate needs a qualified wake-pin pulse; sleep
// and tag-detect wake on masked sources; host commands are taken only in
// active states; a reset command waits for slave select to go high.
// Assumes host command inputs and osc_ready are synchronous to clk.
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int MIN_LOW_TICKS   = 8,
    parameter int POR_GUARD_TICKS = 4,
    parameter int OSC_SETUP_CYC   = 271200,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  slow_tick,
    input  logic                  wake_n,
    input  logic                  ss_n,
    input  logic                  strap0,
    input  logic                  strap1,
    input  logic                  tmr_evt,
    input  logic                  fld_evt,
    input  logic                  tag_evt,
    input  logic                  cmd_valid,
    input  logic [CMD_W-1:0]      cmd_op,
    input  logic [WAKE_SRC_N-1:0] cmd_arg,
    input  logic                  osc_ready,
    output logic [2:0]            state,
    output logic                  hf_clk_en,
    output logic                  if_sel
);

    localparam int OSC_W = $clog2(OSC_SETUP_CYC + 1);
    localparam logic [OSC_W-1:0] OSC_LAST = OSC_W'(OSC_SETUP_CYC - 1);

    pwr_state_e      state_q, state_nxt;
    logic [1:0]      pins_s;
    logic            pin_low, ss_low, ss_hi;
    logic            arm, fall_evt, qual_evt;
    logic            wake_hit, mask_load;
    logic            cmd_accept, rst_pend_q, rst_exec;
    logic [OSC_W-1:0] osc_cnt;
    logic            if_sel_q;

    pwr_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wake_n, ss_n}),
        .q     (pins_s)
    );

    assign pin_low = !pins_s[1];
    assign ss_low  = !pins_s[0];
    assign ss_hi   = pins_s[0];
    assign arm     = (state_q == ST_PWRUP) || (state_q == ST_HIBER);

    pwr_pulse_qual #(
        .MIN_LOW_TICKS   (MIN_LOW_TICKS),
        .POR_GUARD_TICKS (POR_GUARD_TICKS)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .pin_low   (pin_low),
        .arm       (arm),
        .fall_evt  (fall_evt),
        .qual_evt  (qual_evt)
    );

    assign cmd_accept = cmd_valid && is_active(state_q) && !rst_pend_q;
    assign mask_load  = cmd_accept && ((cmd_op == OP_SLEEP) || (cmd_op == OP_TAGDET));
    assign rst_exec   = rst_pend_q && ss_hi && is_active(state_q);

    pwr_wake_sel u_wsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_load (mask_load),
        .mask_in   (cmd_arg),
        .in_sleep  (state_q == ST_SLEEP),
        .in_tag    (state_q == ST_TAGDET),
        .tmr_evt   (tmr_evt),
        .pin_low   (pin_low),
        .ss_low    (ss_low),
        .fld_evt   (fld_evt),
        .tag_evt   (tag_evt),
        .wake_hit  (wake_hit)
    );

    // Next-state selection; a pending reset outranks any command.
    always_comb begin
        state_nxt = state_q;
        case (state_q)
            ST_PWRUP, ST_HIBER: begin
                if (qual_evt) state_nxt = ST_OSCWAIT;
            end
            ST_SLEEP, ST_TAGDET: begin
                if (wake_hit) state_nxt = ST_OSCWAIT;
            end
            ST_OSCWAIT: begin
                if (osc_ready || (osc_cnt == OSC_LAST)) state_nxt = ST_READY;
            end
            default: begin
                if (rst_exec) begin
                    state_nxt = ST_PWRUP;
                end else if (cmd_accept) begin
                    case (cmd_op)
                        OP_HIBER:  state_nxt = ST_HIBER;
                        OP_SLEEP:  state_nxt = ST_SLEEP;
                        OP_TAGDET: state_nxt = ST_TAGDET;
                        OP_READER: state_nxt = ST_READER;
                        OP_CARD:   state_nxt = ST_CARD;
                        default:   state_nxt = state_q;
                    endcase
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_nxt;
    end

    // Oscillator setup counter, running only during oscillator wait.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_OSCWAIT) begin
            osc_cnt <= '0;
        end else if (osc_cnt != OSC_LAST) begin
            osc_cnt <= osc_cnt + 1'b1;
        end
    end

    // Reset request: set by command, cleared when it executes.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_exec) begin
            rst_pend_q <= 1'b0;
        end else if (cmd_accept && cmd_op == OP_RESET) begin
            rst_pend_q <= 1'b1;
        end
    end

    // Interface strap capture on the qualifying-state falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_sel_q <= 1'b0;
        end else if (fall_evt) begin
            if_sel_q <= strap0 && !strap1;
        end
    end

    assign state     = state_q;
    assign hf_clk_en = state_q[2];
    assign if_sel    = if_sel_q;

    // Power-up/hibernate exit only to oscillator wait, after qualification.
    p_deep_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_PWRUP || $past(state_q) == ST_HIBER) && state_q != $past(state_q))
        |-> (state_q == ST_OSCWAIT && $past(qual_evt)));

    // Sleep/tag-detect exit only to oscillator wait, on a selected source.
    p_lp_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_SLEEP || $past(state_q) == ST_TAGDET) && state_q != $past(state_q))
        |-> (state_q == ST_OSCWAIT && $past(wake_hit)));

    // Ready is reached from oscillator wait only by ready flag or timeout.
    p_ready_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_OSCWAIT && state_q == ST_READY)
        |-> ($past(osc_ready) || $past(osc_cnt) == OSC_LAST));

    // Return to power-up from an active state needs slave select high.
    p_reset_ss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_active($past(state_q)) && state_q == ST_PWRUP) |-> $past(ss_hi));

    // The interface flag changes only after a strap-capture edge.
    p_ifsel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall_evt) |-> $stable(if_sel_q));

endmodule

// File: tb/pwr_wake_ctrl_tb.sv
// Self-checking bench for the power-state sequencer: directed boot,
// command and reset cases plus seeded random wake-source trials.
module pwr_wake_ctrl_tb;

    localparam int MIN_T   = 8;
    localparam int GUARD_T = 16;
    localparam int OSC_C   = 64;
    localparam int TICK_P  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       wake_n = 1'b1, ss_n = 1'b1;
    logic       strap0 = 1'b1, strap1 = 1'b0;
    logic       tmr_evt = 1'b0, fld_evt = 1'b0, tag_evt = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = 4'd0, cmd_arg = 4'd0;
    logic       osc_ready = 1'b0;
    logic [2:0] state;
    logic       hf_clk_en, if_sel;

    int n_run = 0, n_fail = 0;
    int tick_div = 0;

    pwr_wake_ctrl #(
        .MIN_LOW_TICKS   (MIN_T),
        .POR_GUARD_TICKS (GUARD_T),
        .OSC_SETUP_CYC   (OSC_C),
        .SYNC_STAGES     (2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wake_n(wake_n),
        .ss_n(ss_n), .strap0(strap0), .strap1(strap1), .tmr_evt(tmr_evt),
        .fld_evt(fld_evt), .tag_evt(tag_evt), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_arg(cmd_arg), .osc_ready(osc_ready),
        .state(state), .hf_clk_en(hf_clk_en), .if_sel(if_sel)
    );

    always #4 clk = ~clk;

    // Slow-clock enable: one cycle in every TICK_P, driven off the edge.
    always @(negedge clk) begin
        tick_div  <= (tick_div == TICK_P-1) ? 0 : tick_div + 1;
        slow_tick <= (tick_div == TICK_P-1);
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_low_for(input int cycles);
        @(negedge clk); wake_n = 1'b0;
        cyc(cycles);
        wake_n = 1'b1;
    endtask

    task automatic send(input logic [3:0] op, input logic [3:0] arg);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk); cmd_valid = 1'b0; cmd_op = 4'd0;
        cyc(2);
    endtask

    // Reset, pass the guard and wake with osc_ready already high.
    task automatic boot();
        @(negedge clk); rst_n = 1'b0; osc_ready = 1'b1;
        cyc(3); rst_n = 1'b1;
        cyc(GUARD_T*TICK_P + 8);
        pin_low_for((MIN_T+3)*TICK_P);
        cyc(4);
    endtask

    // Expected wake decision from the mask rules (R9, R10).
    function automatic bit exp_wake(input bit is_tag, input logic [3:0] m, input int src);
        case (src)
            0: return m[0];
            1: return m[1];
            2: return m[2];
            3: return m[3] && !is_tag;
            default: return m[3] && is_tag;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0C11));
        fork
            begin : main
                // R1 reset state
                cyc(3);
                check("R1 state", state, 0);
                check("R1 hf_clk_en", hf_clk_en, 0);
                check("R1 if_sel", if_sel, 0);
                @(negedge clk); rst_n = 1'b1;

                // R2 pulse inside the guard window is ignored
                pin_low_for(10*TICK_P);
                cyc(GUARD_T*TICK_P);
                check("R2 guard", state, 0);

                // R3 short pulse ignored
                pin_low_for(5*TICK_P);
                cyc(8);
                check("R3 short pulse", state, 0);

                // R3 long pulse qualifies; R4 straps 1/0 select
                pin_low_for(12*TICK_P);
                cyc(4);
                check("R3 long pulse", state, 4);
                check("R7 hf on in wait", hf_clk_en, 1);
                check("R4 if_sel set", if_sel, 1);

                // R5 timeout path
                cyc(OSC_C + 6);
                check("R5 timeout", state, 5);

                // R6 commands
                send(4'd4, 4'd0); check("R6 reader", state, 6);
                send(4'd5, 4'd0); check("R6 card", state, 7);
                send(4'd9, 4'd0); check("R6 unknown", state, 7);

                // R7 hibernate ignores commands
                send(4'd1, 4'd0); check("R7 hibernate", state, 1);
                check("R7 hf off", hf_clk_en, 0);
                send(4'd4, 4'd0); check("R7 cmd ignored", state, 1);
                pin_low_for(4*TICK_P); cyc(6);
                check("R3 hib short", state, 1);

                // R4 relatch from hibernate; R5 early ready
                strap0 = 1'b0; strap1 = 1'b0; osc_ready = 1'b1;
                pin_low_for(12*TICK_P); cyc(4);
                check("R5 early ready", state, 5);
                check("R4 relatch", if_sel, 0);

                // R4 wake from sleep leaves if_sel alone
                strap0 = 1'b1;
                send(4'd2, 4'b0010); check("R9 sleep", state, 2);
                pin_low_for(3); cyc(6);
                check("R9 pin wake", state, 5);
                check("R4 no latch in sleep", if_sel, 0);

                // R8 reset waits for slave select high
                send(4'd4, 4'd0);
                @(negedge clk); ss_n = 1'b0; cyc(3);
                send(4'd6, 4'd0); cyc(5);
                check("R8 pending", state, 6);
                // coincidence: card command held across ss rise
                @(negedge clk); cmd_valid = 1'b1; cmd_op = 4'd5;
                cyc(2); ss_n = 1'b1; cyc(4);
                cmd_valid = 1'b0; cmd_op = 4'd0; cyc(3);
                check("R8 reset wins", state, 0);
                cyc(5);
                check("R8 stays", state, 0);

                // R9/R10 random wake trials
                for (int i = 0; i < 24; i++) begin
                    logic [3:0] m;
                    bit is_tag;
                    int src;
                    bit woke;
                    boot();
                    m      = 4'($urandom % 16);
                    is_tag = 1'($urandom % 2);
                    src    = int'($urandom % 5);
                    send(is_tag ? 4'd3 : 4'd2, m);
                    check(is_tag ? "R10 enter" : "R9 enter", state, is_tag ? 3 : 2);
                    send(4'd4, 4'd0);
                    check("R7 lp cmd ignored", state, is_tag ? 3 : 2);
                    @(negedge clk);
                    case (src)
                        0: tmr_evt = 1'b1;
                        1: wake_n  = 1'b0;
                        2: ss_n    = 1'b0;
                        3: fld_evt = 1'b1;
                        default: tag_evt = 1'b1;
                    endcase
                    @(negedge clk); tmr_evt = 1'b0; fld_evt = 1'b0; tag_evt = 1'b0;
                    cyc(2); wake_n = 1'b1; ss_n = 1'b1;
                    cyc(8);
                    woke = exp_wake(is_tag, m, src);
                    check(is_tag ? "R10 wake" : "R9 wake", state,
                          woke ? 5 : (is_tag ? 3 : 2));
                end
                disable wd;
            end
            begin : wd
                repeat (150000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog expired");
                disable main;
            end
        join
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule